// File: doc/BRIEF.md
# Free-Running Capture Timer

This block keeps a 16-bit up-counter that advances once every sixteen input clock cycles and can never be stopped, loaded or cleared by software. Three event pins each have an input-capture channel. When the edge a channel is set to watch arrives on its pin, the channel stores the counter value. If that channel's interrupt is enabled, the same edge also sets a sticky interrupt flag. A fourth channel serves an external-interrupt pin. It samples a second counter that runs in lockstep with the main one, and it has its own configuration register. That register picks the edge, enables the interrupt and decides whether the edge also captures.

Channel 2 has a dedicated capture register. Channels 0 and 1 share storage with a down-counting timer and its reload register. A mode bit chooses how that pair behaves. In timer mode the pair counts down at the tick rate and reloads itself on underflow. In capture mode the same two registers become the capture registers for channels 0 and 1. Software reaches every register through a simple word-addressed read/write bus. Reads return data one cycle after the request.

Top module: `capt_timer`

## Requirements
- R1: After reset the main counter reads 0, and it then increases by exactly 1 on every 16th clock edge. After n clock edges out of reset its value is floor(n/16) modulo 2^16. The main counter is at address 0.
- R2: A bus write to address 0 has no effect on the main counter.
- R3: An event pin passes through a two-flop synchronizer. A pin change driven between edges c and c+1 triggers its channel at edge c+3. When that channel captures, its register then holds the main counter value from just before edge c+3. The capture registers are: channel 2 at address 1, channel 1 at address 2 and channel 0 at address 3 (the last two in capture mode only).
- R4: In the edge register (address 4), bit i selects the trigger edge of channel i: 1 means rising and 0 means falling. An edge of the other polarity neither captures nor sets a flag.
- R5: In the edge register, bit 3+i enables the interrupt of channel i. A triggering edge sets flag bit i of the flag register (address 9), which also drives irq_o[i]. A triggering edge with the interrupt disabled still captures and leaves the flag at 0.
- R6: Flags stay set until a bus write to address 9 with a 1 in that bit position. Writing a 0 leaves the flag unchanged. If a set and a clear reach the same flag on the same edge, the flag stays set.
- R7: While bit 0 of the mode register (address 5) is 0, address 2 is a writable down-timer and address 3 is its writable reload value. On each counter tick the timer loads the reload value if it is 0, and otherwise decrements by 1. Edges on channels 0 and 1 do not change either register.
- R8: While mode bit 0 is 1, addresses 2 and 3 hold the channel 1 and channel 0 captures. Bus writes to them are ignored, and the timer does not count.
- R9: The external channel watches pin ext_pin. Its configuration register (address 6) has three bits: bit 0 selects the edge (1 means rising), bit 1 enables the interrupt to flag bit 3, and bit 2 enables capture into address 7. The second counter can be read at address 8 and always equals the main counter.
- R10: A read request is answered by rd_data one cycle later, and rd_data holds its value between reads. A read that falls on the same edge as a capture into the register being read returns the old value. The new value appears on the following read.
- R11: Synchronous active-high reset clears the counters, the control registers, the capture registers and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| cap_pin | input | 3 | Event pins of channels 0 to 2 |
| ext_pin | input | 1 | External-interrupt event pin |
| irq_o | output | 4 | Sticky interrupt flags, bit 3 belongs to the external channel |

## Verification
The bench counts the clock edges since reset and uses that count to predict every result. A counter read issued after c edges returns c/16, because the read register samples on edge c+1. A capture triggered by a pin that toggles after c edges is due at edge c+3 and holds (c+2)/16. The captured value and the interrupt flag are checked only several cycles after that edge. The two same-edge collisions are placed so that they fall exactly on edge c+3: the read that must return the old value, and the flag clear that must lose to the set. Expected down-timer values are stepped edge by edge from the cycle in which the write takes effect.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ADDR_W = 4;
  localparam int N_PIN  = 3;
  localparam int IRQ_W  = N_PIN + 1;
  localparam int EDGE_W = 2 * N_PIN;

  localparam logic [ADDR_W-1:0] A_CNT    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CAP    = 4'd1;
  localparam logic [ADDR_W-1:0] A_TMR    = 4'd2;
  localparam logic [ADDR_W-1:0] A_RLD    = 4'd3;
  localparam logic [ADDR_W-1:0] A_EDGE   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd5;
  localparam logic [ADDR_W-1:0] A_EXTCFG = 4'd6;
  localparam logic [ADDR_W-1:0] A_EXTCAP = 4'd7;
  localparam logic [ADDR_W-1:0] A_EXTCNT = 4'd8;
  localparam logic [ADDR_W-1:0] A_IRQ    = 4'd9;

  typedef struct packed {
    logic cap_en;
    logic irq_en;
    logic rise;
  } ext_cfg_t;
endpackage

// File: rtl/ct_tick_counter.sv
module ct_tick_counter #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_o <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= lvl;
    end
  end

  assign evt_o = rise_sel_i ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/ct_pair.sv
module ct_pair #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             cap_mode_i,
  input  logic             wr_tmr_i,
  input  logic             wr_rld_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cap_tmr_i,
  input  logic             cap_rld_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] tmr_o,
  output logic [CNT_W-1:0] rld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_o <= '0;
      rld_o <= '0;
    end else if (cap_mode_i) begin
      if (cap_tmr_i) tmr_o <= cnt_i;
      if (cap_rld_i) rld_o <= cnt_i;
    end else begin
      if (wr_tmr_i)    tmr_o <= wdata_i;
      else if (tick_i) tmr_o <= (tmr_o == '0) ? rld_o : tmr_o - 1'b1;
      if (wr_rld_i)    rld_o <= wdata_i;
    end
  end
endmodule

// File: rtl/capt_timer.sv
module capt_timer
  import ct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [N_PIN-1:0]  cap_pin,
  input  logic              ext_pin,
  output logic [IRQ_W-1:0]  irq_o
);
  logic             tick, ext_tick;
  logic [CNT_W-1:0] main_cnt, ext_cnt;
  logic [CNT_W-1:0] tmr_q, rld_q, cap_ded_q, ext_cap_q;
  logic [EDGE_W-1:0] edge_q;
  logic             mode_q;
  ext_cfg_t         ext_cfg_q;
  logic [N_PIN-1:0] evt;
  logic             ext_evt;
  logic [IRQ_W-1:0] set_vec, clr_vec;

  ct_tick_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_main_cnt (
    .clk(clk), .rst(rst), .tick_o(tick), .cnt_o(main_cnt)
  );

  ct_tick_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_ext_cnt (
    .clk(clk), .rst(rst), .tick_o(ext_tick), .cnt_o(ext_cnt)
  );

  for (genvar i = 0; i < N_PIN; i++) begin : g_chan
    ct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .pin_i(cap_pin[i]),
      .rise_sel_i(edge_q[i]), .evt_o(evt[i])
    );
    assign set_vec[i] = evt[i] & edge_q[N_PIN+i];
  end

  ct_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin),
    .rise_sel_i(ext_cfg_q.rise), .evt_o(ext_evt)
  );
  assign set_vec[N_PIN] = ext_evt & ext_cfg_q.irq_en;

  ct_pair #(.CNT_W(CNT_W)) u_pair (
    .clk(clk), .rst(rst), .tick_i(tick), .cap_mode_i(mode_q),
    .wr_tmr_i(wr_en && addr == A_TMR),
    .wr_rld_i(wr_en && addr == A_RLD),
    .wdata_i(wr_data),
    .cap_tmr_i(evt[1]), .cap_rld_i(evt[0]),
    .cnt_i(main_cnt), .tmr_o(tmr_q), .rld_o(rld_q)
  );

  assign clr_vec = (wr_en && addr == A_IRQ) ? wr_data[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q    <= '0;
      mode_q    <= 1'b0;
      ext_cfg_q <= '0;
      cap_ded_q <= '0;
      ext_cap_q <= '0;
      irq_o     <= '0;
    end else begin
      if (wr_en && addr == A_EDGE)   edge_q    <= wr_data[EDGE_W-1:0];
      if (wr_en && addr == A_MODE)   mode_q    <= wr_data[0];
      if (wr_en && addr == A_EXTCFG) ext_cfg_q <= ext_cfg_t'(wr_data[2:0]);
      if (evt[2])                    cap_ded_q <= main_cnt;
      if (ext_evt && ext_cfg_q.cap_en) ext_cap_q <= ext_cnt;
      irq_o <= (irq_o & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CNT:    rd_data <= main_cnt;
        A_CAP:    rd_data <= cap_ded_q;
        A_TMR:    rd_data <= tmr_q;
        A_RLD:    rd_data <= rld_q;
        A_EDGE:   rd_data <= CNT_W'(edge_q);
        A_MODE:   rd_data <= CNT_W'(mode_q);
        A_EXTCFG: rd_data <= CNT_W'(ext_cfg_q);
        A_EXTCAP: rd_data <= ext_cap_q;
        A_EXTCNT: rd_data <= ext_cnt;
        A_IRQ:    rd_data <= CNT_W'(irq_o);
        default:  rd_data <= '0;
      endcase
    end
  end

  logic unused_tick;
  assign unused_tick = ext_tick;
endmodule

// File: rtl/ct_checker.sv
module ct_checker
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  rd_data,
  input logic [IRQ_W-1:0]  irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ext_cnt,
  input logic [CNT_W-1:0]  cap2,
  input logic [N_PIN-1:0]  evt
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r9_twin_count: assert property (@(posedge clk) disable iff (rst)
    cnt == ext_cnt);

  a_r3_cap_on_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap2) |-> $past(evt[2]));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_IRQ) |=> ((irq_o & $past(irq_o)) == $past(irq_o)));

  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (irq_o == '0));
endmodule

bind capt_timer ct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .irq_o(irq_o), .cnt(main_cnt), .ext_cnt(ext_cnt),
  .cap2(cap_ded_q), .evt(evt)
);

// File: tb/sim_capt_timer.sv
module sim_capt_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  cap_pin = '0;
  logic        ext_pin = 1'b0;
  logic [3:0]  irq_o;

  int checks = 0, errors = 0, cyc = 0;

  capt_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cap_pin(cap_pin),
    .ext_pin(ext_pin), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // vector: [8] ext cap_en, [7:6] channel (3 = ext), [5] rising,
  // [4] irq_en, [3] start level, [2] end level, [1] exp capture, [0] exp flag
  localparam logic [8:0] VEC [8] = '{
    9'b1_00_1_1_0_1_1_1,
    9'b1_00_1_1_1_0_0_0,
    9'b1_01_0_1_1_0_1_1,
    9'b1_01_0_0_1_0_1_0,
    9'b1_10_1_0_0_1_1_0,
    9'b1_10_0_1_0_1_0_0,
    9'b1_11_1_1_0_1_1_1,
    9'b0_11_0_1_1_0_0_1
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v, output int c);
    c = cyc; rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int cap_addr(input int ch);
    case (ch)
      0: return 3;
      1: return 2;
      2: return 1;
      default: return 7;
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, old;
    int c, c0, w, tv;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R11: reset state
    chk("R11 irq", int'(irq_o), 0);
    for (int a = 1; a < 10; a++) begin
      if (a == 8) continue;
      rd(4'(a), v, c);
      chk("R11 reg", int'(v), 0);
    end

    // R1: counter rate
    idle(37);
    rd(4'd0, v, c);
    chk("R1 cnt", int'(v), c / 16);
    idle(100);
    rd(4'd0, v, c);
    chk("R1 cnt later", int'(v), c / 16);

    // R2: write to counter ignored
    wr(4'd0, 16'hBEEF);
    rd(4'd0, v, c);
    chk("R2 cnt", int'(v), c / 16);

    // R9: twin counter
    rd(4'd8, v, c);
    chk("R9 twin", int'(v), c / 16);

    // table walk (capture mode)
    wr(4'd5, 16'd1);
    foreach (VEC[k]) begin
      int ch;
      logic [8:0] e;
      e = VEC[k];
      ch = int'(e[7:6]);
      if (ch == 3) ext_pin = e[3]; else cap_pin[ch] = e[3];
      idle(6);
      if (ch == 3) begin
        wr(4'd4, 16'd0);
        wr(4'd6, 16'({e[8], e[4], e[5]}));
      end else begin
        wr(4'd6, 16'd0);
        wr(4'd4, 16'((int'(e[5]) << ch) | (int'(e[4]) << (3 + ch))));
      end
      wr(4'd9, 16'hF);
      rd(4'(cap_addr(ch)), old, c);
      idle(3);
      c0 = cyc;
      if (ch == 3) ext_pin = e[2]; else cap_pin[ch] = e[2];
      idle(6);
      rd(4'(cap_addr(ch)), v, c);
      if (ch == 3) chk("R9 ext capture", int'(v), e[1] ? (c0 + 2) / 16 : int'(old));
      else if (e[5] == e[2]) chk("R3 capture", int'(v), e[1] ? (c0 + 2) / 16 : int'(old));
      else chk("R4 wrong edge", int'(v), int'(old));
      if (ch == 3) chk("R9 ext flag", int'(irq_o[3]), int'(e[0]));
      else chk("R5 flag", int'(irq_o[ch]), int'(e[0]));
    end

    // R8: pair writes ignored, timer frozen in capture mode
    rd(4'd2, old, c);
    wr(4'd2, 16'h1234);
    wr(4'd3, 16'h4321);
    idle(40);
    rd(4'd2, v, c);
    chk("R8 tmr frozen", int'(v), int'(old));

    // R10: read collides with capture on ch2 (rising)
    wr(4'd6, 16'd0);
    wr(4'd4, 16'h0024);
    wr(4'd9, 16'hF);
    cap_pin[2] = 1'b0;
    idle(8);
    rd(4'd1, old, c);
    idle(20);
    c0 = cyc;
    cap_pin[2] = 1'b1;
    idle(2);
    rd(4'd1, v, c);
    chk("R10 old on collision", int'(v), int'(old));
    rd(4'd1, v, c);
    chk("R10 new after", int'(v), (c0 + 2) / 16);

    // R6: clear loses to set on same edge; 0 write no effect; 1 clears
    wr(4'd9, 16'hF);
    cap_pin[2] = 1'b0;
    idle(6);
    cap_pin[2] = 1'b1;
    idle(2);
    wr(4'd9, 16'h4);
    chk("R6 set wins", int'(irq_o[2]), 1);
    wr(4'd9, 16'h0);
    chk("R6 zero write", int'(irq_o[2]), 1);
    wr(4'd9, 16'h4);
    chk("R6 w1c", int'(irq_o[2]), 0);

    // R7: timer mode
    wr(4'd5, 16'd0);
    wr(4'd3, 16'd2);
    w = cyc;
    wr(4'd2, 16'd1);
    idle(45);
    rd(4'd2, v, c);
    tv = 1;
    for (int m = w + 2; m <= c; m++)
      if (m % 16 == 0) tv = (tv == 0) ? 2 : tv - 1;
    chk("R7 timer", int'(v), tv);
    cap_pin[0] = 1'b0;
    wr(4'd4, 16'h0009);
    idle(4);
    cap_pin[0] = 1'b1;
    idle(6);
    rd(4'd3, v, c);
    chk("R7 no capture", int'(v), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule